// File: doc/BRIEF.md
# OTP Fuse Array Command Controller

This block sits between a simple register port and a one-time-programmable fuse array. Software raises a power request, waits for the array to report that it is powered, and then starts commands by writing a control word. Three commands exist. A read copies one fuse word into a shadow word that software reads back. A program burns a value taken from a separate write-data register. A permanent lock sets the lock bits that belong to one word. While a command runs, the block reports busy and the current mode. After a program it compares what the array holds against what it was asked to set and raises a failure flag if they differ. It keeps one error bit and one disturbed bit per word, packed 32 words to a register.

The lock command turns a word index into a lock-row address and a bit pattern. Words below a configurable boundary take two bits each, eight words to a row. Words at or above the boundary take one bit each, sixteen words to a row, starting two rows further on. The fuse array itself is outside the block. The block drives a write strobe, a region select, an address and a data word, and it samples the array's read data and its disturbed flag.

Top module: `fuse_cmd_ctrl`

## Requirements
- R1: Bit 0 of the configuration register (offset 0x000) requests array power. Status bit 5 rises exactly PWR_UP_CYC clock edges after the write that sets the request, and falls exactly PWR_DN_CYC edges after the write that clears it.
- R2: Register map:
  - 0x000 configuration
  - 0x004 control
  - 0x008 write data
  - 0x00C status (read only)
  - 0x040+4*b error bank b
  - 0x080+4*b disturbed bank b
  - 0x200+4*i shadow word i

  Every read request returns its data on bus_rdata with bus_rvalid high in the following cycle. Unmapped or misaligned addresses read as 0.
- R3: A control write carries the word index in bits 7:0. Bit 9 set selects lock. Otherwise bit 8 set selects program. Otherwise the command is a read.
- R4: Status bit 3 (busy) is high for exactly BUSY_CYC cycles after an accepted control write. While busy, status bits 2:0 give the mode: 1 read, 2 program, 3 lock. When idle the mode is 0.
- R5: When a read completes, shadow word i holds the array word i. The disturbed bit of word i (bank i>>5, bit i&31) takes the array's disturbed flag.
- R6: Programming only moves fuse bits from 0 to 1. The array word becomes the old contents OR the write-data value.
- R7: If any bit requested by a program does not read back as 1, status bit 4 is set and the error bit of that word is set. Status bit 4 clears when the next command is accepted. A successful program of the word clears its error bit.
- R8: A lock of word i below UPPER_BASE writes lock row i>>3 with pattern 3<<(2*(i&7)).
- R9: A lock of word i at or above UPPER_BASE writes lock row (i>>4)+2 with pattern 1<<(i&15).
- R10: A control write while busy, or while status bit 5 is low, is ignored. The status stays unchanged and no shadow word changes.
- R11: A control write whose index exceeds MAX_IDX is rejected and starts no command.
- R12: After reset, all registers, shadow words and bitmaps read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request, accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| arr_we | output | 1 | Array write strobe (program or lock) |
| arr_lock_sel | output | 1 | Selects the lock rows instead of the fuse words |
| arr_addr | output | IDX_W | Fuse word index or lock row |
| arr_wdata | output | 32 | Bits to set in the array |
| arr_rdata | input | 32 | Array contents at arr_addr (combinational) |
| arr_disturb | input | 1 | Array flags the addressed word as marginal |

## Verification
Timing is counted from the clock edge that accepts a register write. The power indication changes PWR_UP_CYC or PWR_DN_CYC edges later. Busy drops BUSY_CYC edges later, and the shadow word, bitmaps and failure flag change on that same edge. Any read returns the state as it stood just before the edge that captures the request. The bench therefore reads status at the last cycle before each change and at the first cycle after it, and checks that the value flips between the two. Full sweeps over all 64 word indices cover programming, read-back and both lock encodings. The expected row and pattern are computed arithmetically and compared with the write strobes seen at the array.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int BUS_AW = 12;
  localparam int DW     = 32;

  localparam logic [BUS_AW-1:0] OFF_CFG    = 12'h000;
  localparam logic [BUS_AW-1:0] OFF_CTRL   = 12'h004;
  localparam logic [BUS_AW-1:0] OFF_WDATA  = 12'h008;
  localparam logic [BUS_AW-1:0] OFF_STAT   = 12'h00C;
  localparam logic [BUS_AW-1:0] OFF_ERR    = 12'h040;
  localparam logic [BUS_AW-1:0] OFF_DIST   = 12'h080;
  localparam logic [BUS_AW-1:0] OFF_SHADOW = 12'h200;

  localparam int CMD_IDX_W = 8;
  localparam int BIT_PROG  = 8;
  localparam int BIT_LOCK  = 9;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_LOCK = 2'd2
  } fcc_op_e;

  localparam logic [2:0] MODE_IDLE = 3'd0;
  localparam logic [2:0] MODE_READ = 3'd1;
  localparam logic [2:0] MODE_PROG = 3'd2;
  localparam logic [2:0] MODE_LOCK = 3'd3;
endpackage

// File: rtl/fcc_power.sv
module fcc_power #(
  parameter int UP_CYC = 3,
  parameter int DN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic on
);
  localparam int MAXD = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
  localparam int CW   = $clog2(MAXD + 1);

  logic          on_q, on_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;

  always_comb begin
    lim   = req ? CW'(UP_CYC - 1) : CW'(DN_CYC - 1);
    on_d  = on_q;
    cnt_d = '0;
    if (req != on_q) begin
      if (cnt_q == lim) begin
        on_d  = req;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      cnt_q <= cnt_d;
    end
  end

  assign on = on_q;
endmodule

// File: rtl/fcc_lockenc.sv
module fcc_lockenc #(
  parameter int IDX_W      = 6,
  parameter int UPPER_BASE = 32
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] row,
  output logic [31:0]      pat
);
  logic upper;

  assign upper = (int'(idx) >= UPPER_BASE);

  always_comb begin
    if (upper) begin
      row = (idx >> 4) + IDX_W'(2);
      pat = 32'd1 << idx[3:0];
    end else begin
      row = idx >> 3;
      pat = 32'd3 << {idx[2:0], 1'b0};
    end
  end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int MAX_IDX    = 63,
  parameter int UPPER_BASE = 32,
  parameter int BUSY_CYC   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  fcc_op_e              cmd_op,
  input  logic [CMD_IDX_W-1:0] cmd_idx,
  input  logic [DW-1:0]        prog_data,
  input  logic                 pwr_on,
  input  logic [DW-1:0]        arr_rdata,
  output logic                 busy,
  output logic [2:0]           mode,
  output logic                 prog_fail,
  output logic                 arr_we,
  output logic                 arr_lock_sel,
  output logic [IDX_W-1:0]     arr_addr,
  output logic [DW-1:0]        arr_wdata,
  output logic                 done,
  output fcc_op_e              done_op,
  output logic [IDX_W-1:0]     done_idx,
  output logic                 done_fail
);
  localparam int CNT_W = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  fcc_op_e          op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d, addr_q, addr_d;
  logic [DW-1:0]    wd_q, wd_d;
  logic             fail_q, fail_d;

  logic [IDX_W-1:0] new_idx, lk_row;
  logic [DW-1:0]    lk_pat;
  logic             accept, last, bad_rb;

  assign new_idx = cmd_idx[IDX_W-1:0];

  fcc_lockenc #(.IDX_W(IDX_W), .UPPER_BASE(UPPER_BASE)) u_lockenc (
    .idx (new_idx),
    .row (lk_row),
    .pat (lk_pat)
  );

  assign accept = cmd_wr && !busy_q && pwr_on && (int'(cmd_idx) <= MAX_IDX);
  assign last   = busy_q && (cnt_q == CNT_W'(BUSY_CYC - 1));
  assign bad_rb = ((arr_rdata & wd_q) != wd_q);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    idx_d  = idx_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    fail_d = fail_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      op_d   = cmd_op;
      idx_d  = new_idx;
      addr_d = (cmd_op == OP_LOCK) ? lk_row : new_idx;
      wd_d   = (cmd_op == OP_LOCK) ? lk_pat : prog_data;
      fail_d = 1'b0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        if (op_q != OP_READ) fail_d = bad_rb;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_READ;
      idx_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      fail_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      idx_q  <= idx_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      fail_q <= fail_d;
    end
  end

  always_comb begin
    mode = MODE_IDLE;
    if (busy_q) begin
      case (op_q)
        OP_PROG: mode = MODE_PROG;
        OP_LOCK: mode = MODE_LOCK;
        default: mode = MODE_READ;
      endcase
    end
  end

  assign busy         = busy_q;
  assign prog_fail    = fail_q;
  assign arr_we       = busy_q && (cnt_q == '0) && (op_q != OP_READ);
  assign arr_lock_sel = busy_q && (op_q == OP_LOCK);
  assign arr_addr     = addr_q;
  assign arr_wdata    = wd_q;
  assign done         = last;
  assign done_op      = op_q;
  assign done_idx     = idx_q;
  assign done_fail    = last && (op_q != OP_READ) && bad_rb;
endmodule

// File: rtl/fcc_store.sv
module fcc_store
  import fcc_pkg::*;
#(
  parameter int N_WORDS = 64,
  parameter int IDX_W   = 6,
  parameter int BK_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  fcc_op_e          done_op,
  input  logic [IDX_W-1:0] done_idx,
  input  logic             done_fail,
  input  logic [DW-1:0]    arr_rdata,
  input  logic             arr_disturb,
  input  logic [IDX_W-1:0] sh_idx,
  input  logic [BK_W-1:0]  bank,
  output logic [DW-1:0]    sh_data,
  output logic [DW-1:0]    err_word,
  output logic [DW-1:0]    dist_word
);
  logic [DW-1:0]      shadow [N_WORDS];
  logic [N_WORDS-1:0] err_q, err_d, dist_q, dist_d;
  logic               rd_done, wr_done;

  assign rd_done = done && (done_op == OP_READ);
  assign wr_done = done && (done_op != OP_READ);

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic sh_en;
    assign sh_en = rd_done && (done_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow[g] <= '0;
      else if (sh_en) shadow[g] <= arr_rdata;
    end
  end

  always_comb begin
    err_d  = err_q;
    dist_d = dist_q;
    if (wr_done) err_d[done_idx]  = done_fail;
    if (rd_done) dist_d[done_idx] = arr_disturb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      dist_q <= '0;
    end else begin
      err_q  <= err_d;
      dist_q <= dist_d;
    end
  end

  assign sh_data   = shadow[sh_idx];
  assign err_word  = err_q[32*bank +: 32];
  assign dist_word = dist_q[32*bank +: 32];
endmodule

// File: rtl/fuse_cmd_ctrl.sv
module fuse_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int N_WORDS    = 64,
  parameter int MAX_IDX    = N_WORDS - 1,
  parameter int UPPER_BASE = 32,
  parameter int BUSY_CYC   = 4,
  parameter int PWR_UP_CYC = 3,
  parameter int PWR_DN_CYC = 2,
  localparam int IDX_W     = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              arr_we,
  output logic              arr_lock_sel,
  output logic [IDX_W-1:0]  arr_addr,
  output logic [31:0]       arr_wdata,
  input  logic [31:0]       arr_rdata,
  input  logic              arr_disturb
);
  localparam int NBANK = N_WORDS / 32;
  localparam int BK_W  = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [BUS_AW-1:0] ERR_END  = OFF_ERR + BUS_AW'(4 * NBANK);
  localparam logic [BUS_AW-1:0] DIST_END = OFF_DIST + BUS_AW'(4 * NBANK);
  localparam logic [BUS_AW-1:0] SH_END   = OFF_SHADOW + BUS_AW'(4 * N_WORDS);

  logic          cfg_pwr, cfg_pwr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          wr_cfg, wr_ctrl, wr_wdata, rd_req;
  logic          pwr_on, busy, prog_fail;
  logic [2:0]    mode;
  fcc_op_e       cmd_op;
  logic          done, done_fail;
  fcc_op_e       done_op;
  logic [IDX_W-1:0] done_idx, sh_idx;
  logic [BK_W-1:0]  bank;
  logic [DW-1:0]    sh_data, err_word, dist_word;
  logic [BUS_AW-1:0] rel_err, rel_dist, rel_sh;
  logic          in_err, in_dist, in_sh;
  logic [DW-1:0] rd_d, rdata_q;
  logic          rvalid_q;

  assign wr_cfg   = bus_valid && bus_write && (bus_addr == OFF_CFG);
  assign wr_ctrl  = bus_valid && bus_write && (bus_addr == OFF_CTRL);
  assign wr_wdata = bus_valid && bus_write && (bus_addr == OFF_WDATA);
  assign rd_req   = bus_valid && !bus_write;

  always_comb begin
    if (bus_wdata[BIT_LOCK])      cmd_op = OP_LOCK;
    else if (bus_wdata[BIT_PROG]) cmd_op = OP_PROG;
    else                          cmd_op = OP_READ;
  end

  always_comb begin
    cfg_pwr_d = wr_cfg ? bus_wdata[0] : cfg_pwr;
    wdata_d   = wr_wdata ? bus_wdata : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pwr <= 1'b0;
      wdata_q <= '0;
    end else begin
      cfg_pwr <= cfg_pwr_d;
      wdata_q <= wdata_d;
    end
  end

  fcc_power #(.UP_CYC(PWR_UP_CYC), .DN_CYC(PWR_DN_CYC)) u_power (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cfg_pwr),
    .on    (pwr_on)
  );

  fcc_seq #(
    .IDX_W      (IDX_W),
    .MAX_IDX    (MAX_IDX),
    .UPPER_BASE (UPPER_BASE),
    .BUSY_CYC   (BUSY_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (wr_ctrl),
    .cmd_op       (cmd_op),
    .cmd_idx      (bus_wdata[CMD_IDX_W-1:0]),
    .prog_data    (wdata_q),
    .pwr_on       (pwr_on),
    .arr_rdata    (arr_rdata),
    .busy         (busy),
    .mode         (mode),
    .prog_fail    (prog_fail),
    .arr_we       (arr_we),
    .arr_lock_sel (arr_lock_sel),
    .arr_addr     (arr_addr),
    .arr_wdata    (arr_wdata),
    .done         (done),
    .done_op      (done_op),
    .done_idx     (done_idx),
    .done_fail    (done_fail)
  );

  assign rel_err  = bus_addr - OFF_ERR;
  assign rel_dist = bus_addr - OFF_DIST;
  assign rel_sh   = bus_addr - OFF_SHADOW;
  assign in_err   = (bus_addr >= OFF_ERR) && (bus_addr < ERR_END) && (bus_addr[1:0] == 2'b00);
  assign in_dist  = (bus_addr >= OFF_DIST) && (bus_addr < DIST_END) && (bus_addr[1:0] == 2'b00);
  assign in_sh    = (bus_addr >= OFF_SHADOW) && (bus_addr < SH_END) && (bus_addr[1:0] == 2'b00);
  assign sh_idx   = IDX_W'(rel_sh >> 2);
  assign bank     = in_dist ? BK_W'(rel_dist >> 2) : BK_W'(rel_err >> 2);

  fcc_store #(.N_WORDS(N_WORDS), .IDX_W(IDX_W), .BK_W(BK_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .done_op     (done_op),
    .done_idx    (done_idx),
    .done_fail   (done_fail),
    .arr_rdata   (arr_rdata),
    .arr_disturb (arr_disturb),
    .sh_idx      (sh_idx),
    .bank        (bank),
    .sh_data     (sh_data),
    .err_word    (err_word),
    .dist_word   (dist_word)
  );

  always_comb begin
    rd_d = '0;
    if (bus_addr == OFF_CFG)        rd_d = {31'd0, cfg_pwr};
    else if (bus_addr == OFF_WDATA) rd_d = wdata_q;
    else if (bus_addr == OFF_STAT)  rd_d = {26'd0, pwr_on, prog_fail, busy, mode};
    else if (in_err)                rd_d = err_word;
    else if (in_dist)               rd_d = dist_word;
    else if (in_sh)                 rd_d = sh_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_d;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk #(
  parameter int BUSY_CYC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        pwr_on,
  input logic        cfg_pwr,
  input logic        prog_fail,
  input logic        arr_we,
  input logic        arr_lock_sel,
  input logic [31:0] arr_wdata,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        bus_rvalid
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 16'd1;
    else           run <= '0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == 16'(BUSY_CYC)));

  p_cmd_powered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_on));

  p_pwr_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> $past(cfg_pwr));

  p_lock_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && arr_lock_sel) |-> ($countones(arr_wdata) == 1 || $countones(arr_wdata) == 2));

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  p_fail_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_fail) |-> $past(busy));
endmodule

bind fuse_cmd_ctrl fcc_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .pwr_on       (pwr_on),
  .cfg_pwr      (cfg_pwr),
  .prog_fail    (prog_fail),
  .arr_we       (arr_we),
  .arr_lock_sel (arr_lock_sel),
  .arr_wdata    (arr_wdata),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_rvalid   (bus_rvalid)
);

// File: tb/sim_fuse_cmd_ctrl.sv
module sim_fuse_cmd_ctrl;
  localparam int CLK_P = 10;
  localparam int NW    = 64;
  localparam int UB    = 32;
  localparam int BUSY  = 4;
  localparam int PU    = 3;
  localparam int PD    = 2;
  localparam int IW    = 6;
  localparam int STUCK_WORD = 9;
  localparam int DIST_WORD  = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic arr_we, arr_lock_sel, arr_disturb;
  logic [IW-1:0] arr_addr;
  logic [31:0] arr_wdata, arr_rdata;

  int n_chk = 0, n_fail = 0;

  logic [31:0] fuse [NW];
  logic [31:0] lrow [NW];
  logic [IW-1:0] lk_addr;
  logic [31:0]   lk_data;

  always #(CLK_P/2) clk = ~clk;

  fuse_cmd_ctrl #(.N_WORDS(NW), .UPPER_BASE(UB), .BUSY_CYC(BUSY),
                  .PWR_UP_CYC(PU), .PWR_DN_CYC(PD)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .arr_we(arr_we), .arr_lock_sel(arr_lock_sel),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .arr_disturb(arr_disturb)
  );

  // behavioural fuse array: word STUCK_WORD has bit 0 stuck at 0
  function automatic logic [31:0] stuck_of(int w);
    return (w == STUCK_WORD) ? 32'h1 : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) begin
        fuse[k] <= '0;
        lrow[k] <= '0;
      end
      lk_addr <= '0;
      lk_data <= '0;
    end else if (arr_we) begin
      if (arr_lock_sel) begin
        lrow[arr_addr] <= lrow[arr_addr] | arr_wdata;
        lk_addr <= arr_addr;
        lk_data <= arr_wdata;
      end else begin
        fuse[arr_addr] <= fuse[arr_addr] | (arr_wdata & ~stuck_of(int'(arr_addr)));
      end
    end
  end

  assign arr_rdata   = arr_lock_sel ? lrow[arr_addr] : fuse[arr_addr];
  assign arr_disturb = !arr_lock_sel && (int'(arr_addr) == DIST_WORD);

  function automatic logic [31:0] pat(int i);
    return (32'h5A3C0000 ^ (32'(i) * 32'h00010100)) | 32'h1;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  logic last_rv;
  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    last_rv = bus_rvalid;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic run_cmd(logic [31:0] ctrl);
    bus_wr(12'h004, ctrl);
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] exp_sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd_chk("R12 status", 12'h00C, 32'h0);
    chk("R2 rvalid after read", 32'(last_rv), 32'h1);
    rd_chk("R12 cfg", 12'h000, 32'h0);
    rd_chk("R12 shadow0", 12'h200, 32'h0);
    rd_chk("R12 err bank0", 12'h040, 32'h0);

    // R10 command while unpowered is ignored
    bus_wr(12'h004, 32'h0000_0003);
    rd_chk("R10 unpowered status", 12'h00C, 32'h0);

    // R1 power-up timing
    bus_wr(12'h000, 32'h1);
    repeat (PU - 1) @(negedge clk);
    rd_chk("R1 power not yet up", 12'h00C, 32'h00);
    rd_chk("R1 power up", 12'h00C, 32'h20);

    // R4 busy duration and program mode on word 0
    bus_wr(12'h008, pat(0));
    bus_wr(12'h004, 32'h100);
    rd_chk("R4 busy prog mode", 12'h00C, 32'h2A);
    repeat (BUSY - 2) @(negedge clk);
    rd_chk("R4 still busy last cycle", 12'h00C, 32'h2A);
    rd_chk("R4 idle after BUSY", 12'h00C, 32'h20);

    // R6 R7 program sweep
    for (int i = 1; i < NW; i++) begin
      bus_wr(12'h008, pat(i));
      run_cmd(32'h100 | 32'(i));
      rd_chk($sformatf("R7 status after program %0d", i), 12'h00C,
             (i == STUCK_WORD) ? 32'h30 : 32'h20);
    end
    rd_chk("R7 err bank0", 12'h040, 32'h1 << STUCK_WORD);
    rd_chk("R7 err bank1", 12'h044, 32'h0);

    // R5 R3 read sweep
    for (int i = 0; i < NW; i++) begin
      run_cmd(32'(i));
      rd_chk($sformatf("R5 shadow %0d", i), 12'h200 + 12'(4 * i),
             pat(i) & ~stuck_of(i));
    end
    rd_chk("R5 disturbed bank0", 12'h080, 32'h0);
    rd_chk("R5 disturbed bank1", 12'h084, 32'h1 << (DIST_WORD - 32));
    rd_chk("R2 misaligned", 12'h202, 32'h0);

    // R6 OR-only programming
    bus_wr(12'h008, 32'hFFFF_0000);
    run_cmd(32'h102);
    run_cmd(32'h2);
    rd_chk("R6 shadow2 ORed", 12'h208, pat(2) | 32'hFFFF_0000);

    // R7 successful program clears error bit
    bus_wr(12'h008, 32'h2);
    run_cmd(32'h100 | STUCK_WORD);
    rd_chk("R7 err cleared", 12'h040, 32'h0);
    rd_chk("R7 fail bit clear", 12'h00C, 32'h20);

    // R10 command while busy is ignored
    bus_wr(12'h008, 32'h8000_0000);
    run_cmd(32'h100 | 40);
    bus_wr(12'h008, 32'h1);
    bus_wr(12'h004, 32'h100 | 41);
    bus_wr(12'h004, 32'd40);
    rd_chk("R10 status unchanged while busy", 12'h00C, 32'h2A);
    repeat (BUSY) @(negedge clk);
    rd_chk("R10 shadow40 untouched", 12'h2A0, pat(40));

    // R11 index above maximum
    bus_wr(12'h004, 32'd64);
    rd_chk("R11 idx 64 rejected", 12'h00C, 32'h20);
    bus_wr(12'h004, 32'h1FF);
    rd_chk("R11 idx 255 rejected", 12'h00C, 32'h20);

    // R8 R9 lock sweep
    bus_wr(12'h004, 32'h200);
    rd_chk("R4 lock mode", 12'h00C, 32'h2B);
    repeat (BUSY - 1) @(negedge clk);
    for (int i = 0; i < NW; i++) begin
      logic [31:0] er, ep;
      if (i > 0) run_cmd(32'h200 | 32'(i));
      if (i < UB) begin
        er = 32'(i >> 3);
        ep = 32'h3 << (2 * (i & 7));
        chk($sformatf("R8 row %0d", i), 32'(lk_addr), er);
        chk($sformatf("R8 pattern %0d", i), lk_data, ep);
      end else begin
        er = 32'((i >> 4) + 2);
        ep = 32'h1 << (i & 15);
        chk($sformatf("R9 row %0d", i), 32'(lk_addr), er);
        chk($sformatf("R9 pattern %0d", i), lk_data, ep);
      end
    end
    chk("R8 lower row full", lrow[0], 32'h0000_FFFF);
    chk("R9 upper row full", lrow[5], 32'h0000_FFFF);
    rd_chk("R7 no fail after locks", 12'h00C, 32'h20);

    // R1 power-down timing
    bus_wr(12'h000, 32'h0);
    repeat (PD - 1) @(negedge clk);
    rd_chk("R1 power still up", 12'h00C, 32'h20);
    rd_chk("R1 power down", 12'h00C, 32'h00);

    // R10 unpowered read of word 40 has no effect
    bus_wr(12'h004, 32'd40);
    rd_chk("R10 no busy unpowered", 12'h00C, 32'h0);
    repeat (BUSY) @(negedge clk);
    exp_sh = pat(40);
    rd_chk("R10 shadow40 still old", 12'h2A0, exp_sh);

    rd_chk("R2 unmapped", 12'h100, 32'h0);
    report();
  end
endmodule